// File: doc/BRIEF.md
# Transmit DMA Channel Runtime Control

This block holds the live, per-channel register set of one transmit channel in a packet DMA engine and runs the state machine that starts, drains and tears down that channel. Software reaches it over a simple 32-bit register port: one write strobe, a byte address and a read data bus that is combinational from the address. The block drives an enable level and a pause level into the transfer datapath. It accepts finished descriptor addresses from the fetch engine and forwards them on a completion-queue output. When a teardown finishes, it pushes a marker word onto the same queue.

The registers are a channel control word, a small window of peer registers, four running counters and a read-only window of state words. The peer registers mirror the remote peripheral's static transfer shape and its enable, flush and teardown controls. The counters cover packets, bytes, a second byte count and the byte count seen by the peer. The state words are filled by the datapath. A counter is cleared by writing back the value just read, so every counter write subtracts.

A finished descriptor is only reported once the peer has accepted at least as many bytes as the channel has sent. The controller walks six states:
- IDLE: the channel is stopped.
- RUN: the channel moves data.
- WAIT: a descriptor is held until the peer catches up.
- SEND: a descriptor address is offered on the queue.
- DRAIN: a teardown is waiting for the datapath and the peer to empty.
- MARK: the teardown marker is offered on the queue.

The transitions are:
- start: IDLE to RUN.
- accept: RUN to WAIT.
- peer-caught-up: WAIT to SEND.
- delivered: SEND to RUN.
- teardown: RUN to DRAIN.
- drained: DRAIN to MARK.
- forced: RUN, WAIT or DRAIN to MARK.
- marker-taken: MARK to IDLE.

Top module: `dma_txch_rt`

## Requirements
- R1: After reset every register and counter reads zero, except bit 1 of the peer enable register (idle), which reads 1. dp_enable, dp_pause, desc_ready and cq_valid are low.
- R2: The control register is at offset 0x000, with enable at bit 31, teardown at bit 30, pause at bit 29 and forced teardown at bit 28. Writing enable alone to an idle channel raises dp_enable within two cycles. dp_pause follows the pause bit only while dp_enable is high.
- R3: The packet counter (offset 0x400) adds 1 per pkt_inc cycle. The byte counter (0x408) and the secondary byte counter (0x410) both add byte_inc. The peer byte counter (0x210) adds peer_byte_inc.
- R4: A write to any counter subtracts the written value, saturating at zero. An increment in the same cycle is added after the subtraction. The other counters are unaffected.
- R5: The peer window starts at 0x200 with a 4-byte stride. Index 0 (0x200) holds the XY word and keeps only bits 31 (burst), 30 (32-bit access), 26:24 (element size) and 11:0 (element count). Index 1 (0x204) stores the written value ANDed with Z_MASK. Index 8 (0x220) is the peer enable register, with enable at bit 31, teardown at 30, pause at 29, flush at 28 and read-only idle at 1. Indices 2, 3, 5 to 7 and 9 to 15 read zero.
- R6: The 32 words from 0x080 to 0x0FC read what the datapath wrote through sd_we, and software writes there have no effect.
- R7: A descriptor is accepted only in RUN. Its address is reported with bit 0 cleared, and only after the peer byte counter is not less than the byte counter.
- R8: Writing enable and teardown (0xC000_0000) moves a running channel to DRAIN. The marker word MARK_WORD (bit 0 set, default 0x0000_0001) is offered only once three things hold: dp_busy is low, the peer enable register has both enable and flush set, and the peer byte counter has caught up.
- R9: Writing enable with forced teardown (0x9000_0000) offers the marker without waiting for the drain conditions.
- R10: When the marker is taken, the control enable, teardown and forced-teardown bits and the peer enable, teardown and flush bits clear, and dp_enable drops. Only a new write of enable restarts the channel.
- R11: While cq_valid is high and cq_ready is low, cq_valid stays high and cq_data holds its value.
- R12: Reads of unmapped offsets return zero, and writes to them change nothing.
- R13: dp_error sets bit 0 of the control register. A control write with bit 0 clear clears it, and a write with bit 0 set leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| dp_enable | output | 1 | Channel enable level to datapath |
| dp_pause | output | 1 | Pause level to datapath |
| dp_busy | input | 1 | Datapath still holds data in flight |
| dp_error | input | 1 | Datapath error pulse |
| pkt_inc | input | 1 | One packet finished |
| byte_inc | input | INC_W | Bytes moved this cycle |
| peer_byte_inc | input | INC_W | Bytes taken by peer this cycle |
| sd_we | input | 1 | State-data word write |
| sd_idx | input | SD_IW | State-data word index |
| sd_data | input | 32 | State-data word value |
| desc_valid | input | 1 | Finished descriptor offered |
| desc_addr | input | 32 | Finished descriptor address |
| desc_ready | output | 1 | Descriptor accepted |
| cq_valid | output | 1 | Completion word valid |
| cq_data | output | 32 | Completion word |
| cq_ready | input | 1 | Completion queue accepts |
| peer_en_o | output | 1 | Peer enable level |
| peer_flush_o | output | 1 | Peer flush level |
| stat_xy | output | 32 | Static XY word to peer |
| stat_z | output | 32 | Static Z word to peer |

## Verification
Two functions can land on one counter in the same clock: a software write that subtracts, and a datapath increment. The bench provokes this by holding byte_inc during the cycle of a write to the byte counter. It judges the result by reading back both the byte counter and the secondary byte counter, expecting the saturated difference plus the increment in one and a plain sum in the other. The teardown handshake is judged the same way, by withholding one drain condition at a time and watching that no marker appears until the last one is met.

// File: rtl/dma_rt_pkg.sv
package dma_rt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_WAIT,
        ST_SEND,
        ST_DRAIN,
        ST_MARK
    } ch_state_e;

    // control word bit positions
    localparam int CTL_EN    = 31;
    localparam int CTL_TD    = 30;
    localparam int CTL_PAUSE = 29;
    localparam int CTL_FTD   = 28;
    localparam int CTL_ERR   = 0;

    // peer enable word bit positions
    localparam int PEN_EN    = 31;
    localparam int PEN_TD    = 30;
    localparam int PEN_PAUSE = 29;
    localparam int PEN_FLUSH = 28;
    localparam int PEN_IDLE  = 1;

    // byte offsets
    localparam int OFS_CTL       = 'h000;
    localparam int OFS_SD_BASE   = 'h080;
    localparam int OFS_PEER_BASE = 'h200;
    localparam int OFS_PKT       = 'h400;
    localparam int OFS_BYTE      = 'h408;
    localparam int OFS_SBYTE     = 'h410;

    // peer window slots
    localparam int PEER_SLOTS = 16;
    localparam int PIDX_XY    = 0;
    localparam int PIDX_Z     = 1;
    localparam int PIDX_PBC   = 4;
    localparam int PIDX_EN    = 8;

    // bits kept in the static XY word
    localparam logic [31:0] XY_KEEP = 32'hC700_0FFF;

    // counter slots
    localparam int CNT_PKT   = 0;
    localparam int CNT_BYTE  = 1;
    localparam int CNT_SBYTE = 2;
    localparam int CNT_PEER  = 3;
    localparam int NUM_CNT   = 4;

endpackage

// File: rtl/rt_counter.sv
module rt_counter #(
    parameter int W  = 32,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sub_en,
    input  logic [W-1:0]  sub_val,
    input  logic [IW-1:0] inc,
    output logic [W-1:0]  cnt
);
    logic [W-1:0] base;

    // subtraction first, saturating, then the datapath increment
    always_comb begin
        if (sub_en) begin
            base = (sub_val >= cnt) ? '0 : (cnt - sub_val);
        end else begin
            base = cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= base + W'(inc);
        end
    end
endmodule

// File: rtl/rt_state_mem.sv
module rt_state_mem #(
    parameter int WORDS = 32,
    parameter int DW    = 32,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [WORDS];

    generate
        for (genvar g = 0; g < WORDS; g++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem[g] <= '0;
                end else if (we && (widx == IW'(g))) begin
                    mem[g] <= wdata;
                end
            end
        end
    endgenerate

    assign rdata = mem[ridx];
endmodule

// File: rtl/rt_ctl_fsm.sv
module rt_ctl_fsm
    import dma_rt_pkg::*;
#(
    parameter logic [31:0] MARK_WORD = 32'h0000_0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_en,
    input  logic        ctl_td,
    input  logic        ctl_ftd,
    input  logic        peer_en,
    input  logic        peer_flush,
    input  logic        dp_busy,
    input  logic        cnt_ok,
    input  logic        desc_valid,
    input  logic [31:0] desc_addr,
    input  logic        cq_ready,
    output ch_state_e   state,
    output logic        run_lvl,
    output logic        desc_ready,
    output logic        cq_valid,
    output logic [31:0] cq_data,
    output logic        tdown_done
);
    ch_state_e   nxt;
    logic [31:0] held_addr;

    // state register and captured descriptor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            held_addr <= '0;
        end else begin
            state <= nxt;
            if (desc_valid && desc_ready) begin
                held_addr <= {desc_addr[31:1], 1'b0};
            end
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (ctl_en && !ctl_td && !ctl_ftd) nxt = ST_RUN;
            end
            ST_RUN: begin
                if (ctl_ftd)         nxt = ST_MARK;
                else if (ctl_td)     nxt = ST_DRAIN;
                else if (desc_valid) nxt = ST_WAIT;
            end
            ST_WAIT: begin
                if (ctl_ftd)     nxt = ST_MARK;
                else if (cnt_ok) nxt = ST_SEND;
            end
            ST_SEND: begin
                if (cq_ready) nxt = ST_RUN;
            end
            ST_DRAIN: begin
                if (ctl_ftd) begin
                    nxt = ST_MARK;
                end else if (!dp_busy && peer_en && peer_flush && cnt_ok) begin
                    nxt = ST_MARK;
                end
            end
            ST_MARK: begin
                if (cq_ready) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run_lvl    = 1'b0;
        desc_ready = 1'b0;
        cq_valid   = 1'b0;
        cq_data    = '0;
        tdown_done = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_RUN: begin
                run_lvl    = 1'b1;
                desc_ready = !ctl_td && !ctl_ftd;
            end
            ST_WAIT:  run_lvl = 1'b1;
            ST_SEND: begin
                run_lvl  = 1'b1;
                cq_valid = 1'b1;
                cq_data  = held_addr;
            end
            ST_DRAIN: run_lvl = 1'b1;
            ST_MARK: begin
                cq_valid   = 1'b1;
                cq_data    = MARK_WORD;
                tdown_done = cq_ready;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dma_txch_rt.sv
module dma_txch_rt
    import dma_rt_pkg::*;
#(
    parameter int          AW        = 12,
    parameter int          INC_W     = 16,
    parameter int          SD_WORDS  = 32,
    parameter logic [31:0] Z_MASK    = 32'h0000_FFFF,
    parameter logic [31:0] MARK_WORD = 32'h0000_0001,
    localparam int         SD_IW     = $clog2(SD_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             dp_enable,
    output logic             dp_pause,
    input  logic             dp_busy,
    input  logic             dp_error,
    input  logic             pkt_inc,
    input  logic [INC_W-1:0] byte_inc,
    input  logic [INC_W-1:0] peer_byte_inc,
    input  logic             sd_we,
    input  logic [SD_IW-1:0] sd_idx,
    input  logic [31:0]      sd_data,
    input  logic             desc_valid,
    input  logic [31:0]      desc_addr,
    output logic             desc_ready,
    output logic             cq_valid,
    output logic [31:0]      cq_data,
    input  logic             cq_ready,
    output logic             peer_en_o,
    output logic             peer_flush_o,
    output logic [31:0]      stat_xy,
    output logic [31:0]      stat_z
);
    localparam int PEER_SPAN = PEER_SLOTS * 4;
    localparam int SD_SPAN   = SD_WORDS * 4;
    localparam int PIW       = $clog2(PEER_SLOTS);

    // ---------------- address decode ----------------
    logic [AW-1:0]    sd_off, peer_off;
    logic             aligned, is_ctl, is_sd, is_peer;
    logic [PIW-1:0]   pidx;
    logic [SD_IW-1:0] sd_ridx;
    logic [NUM_CNT-1:0] is_cnt;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign sd_off   = bus_addr - AW'(OFS_SD_BASE);
    assign peer_off = bus_addr - AW'(OFS_PEER_BASE);
    assign is_ctl   = (bus_addr == AW'(OFS_CTL));
    assign is_sd    = aligned && (bus_addr >= AW'(OFS_SD_BASE))
                    && (sd_off < AW'(SD_SPAN));
    assign is_peer  = aligned && (bus_addr >= AW'(OFS_PEER_BASE))
                    && (peer_off < AW'(PEER_SPAN));
    assign pidx     = peer_off[2 +: PIW];
    assign sd_ridx  = sd_off[2 +: SD_IW];

    assign is_cnt[CNT_PKT]   = (bus_addr == AW'(OFS_PKT));
    assign is_cnt[CNT_BYTE]  = (bus_addr == AW'(OFS_BYTE));
    assign is_cnt[CNT_SBYTE] = (bus_addr == AW'(OFS_SBYTE));
    assign is_cnt[CNT_PEER]  = is_peer && (pidx == PIW'(PIDX_PBC));

    // ---------------- counters ----------------
    logic [INC_W-1:0] cnt_inc [NUM_CNT];
    logic [31:0]      cnt_val [NUM_CNT];
    logic             cnt_ok;

    assign cnt_inc[CNT_PKT]   = INC_W'(pkt_inc);
    assign cnt_inc[CNT_BYTE]  = byte_inc;
    assign cnt_inc[CNT_SBYTE] = byte_inc;
    assign cnt_inc[CNT_PEER]  = peer_byte_inc;

    generate
        for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
            rt_counter #(
                .W  (32),
                .IW (INC_W)
            ) u_cnt (
                .clk     (clk),
                .rst_n   (rst_n),
                .sub_en  (bus_we && is_cnt[c]),
                .sub_val (bus_wdata),
                .inc     (cnt_inc[c]),
                .cnt     (cnt_val[c])
            );
        end
    endgenerate

    assign cnt_ok = (cnt_val[CNT_PEER] >= cnt_val[CNT_BYTE]);

    // ---------------- state-data window ----------------
    logic [31:0] sd_rdata;

    rt_state_mem #(
        .WORDS (SD_WORDS),
        .DW    (32)
    ) u_sd (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sd_we),
        .widx  (sd_idx),
        .wdata (sd_data),
        .ridx  (sd_ridx),
        .rdata (sd_rdata)
    );

    // ---------------- control and peer registers ----------------
    logic ctl_en, ctl_td, ctl_pause, ctl_ftd, ctl_err;
    logic pen_en, pen_td, pen_pause, pen_flush;
    logic [31:0] xy_q, z_q;
    logic ctl_wr, pen_wr, tdown_done, run_lvl;
    ch_state_e fsm_state;

    assign ctl_wr = bus_we && is_ctl;
    assign pen_wr = bus_we && is_peer && (pidx == PIW'(PIDX_EN));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en    <= 1'b0;
            ctl_td    <= 1'b0;
            ctl_pause <= 1'b0;
            ctl_ftd   <= 1'b0;
            ctl_err   <= 1'b0;
        end else begin
            if (tdown_done) begin
                ctl_en  <= 1'b0;
                ctl_td  <= 1'b0;
                ctl_ftd <= 1'b0;
            end else if (ctl_wr) begin
                ctl_en    <= bus_wdata[CTL_EN];
                ctl_td    <= bus_wdata[CTL_TD];
                ctl_pause <= bus_wdata[CTL_PAUSE];
                ctl_ftd   <= bus_wdata[CTL_FTD];
            end
            ctl_err <= (ctl_wr ? (ctl_err & bus_wdata[CTL_ERR]) : ctl_err) | dp_error;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pen_en    <= 1'b0;
            pen_td    <= 1'b0;
            pen_pause <= 1'b0;
            pen_flush <= 1'b0;
            xy_q      <= '0;
            z_q       <= '0;
        end else begin
            if (tdown_done) begin
                pen_en    <= 1'b0;
                pen_td    <= 1'b0;
                pen_flush <= 1'b0;
            end else if (pen_wr) begin
                pen_en    <= bus_wdata[PEN_EN];
                pen_td    <= bus_wdata[PEN_TD];
                pen_pause <= bus_wdata[PEN_PAUSE];
                pen_flush <= bus_wdata[PEN_FLUSH];
            end
            if (bus_we && is_peer && (pidx == PIW'(PIDX_XY))) begin
                xy_q <= bus_wdata & XY_KEEP;
            end
            if (bus_we && is_peer && (pidx == PIW'(PIDX_Z))) begin
                z_q <= bus_wdata & Z_MASK;
            end
        end
    end

    // ---------------- controller ----------------
    rt_ctl_fsm #(
        .MARK_WORD (MARK_WORD)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_en     (ctl_en),
        .ctl_td     (ctl_td),
        .ctl_ftd    (ctl_ftd),
        .peer_en    (pen_en),
        .peer_flush (pen_flush),
        .dp_busy    (dp_busy),
        .cnt_ok     (cnt_ok),
        .desc_valid (desc_valid),
        .desc_addr  (desc_addr),
        .cq_ready   (cq_ready),
        .state      (fsm_state),
        .run_lvl    (run_lvl),
        .desc_ready (desc_ready),
        .cq_valid   (cq_valid),
        .cq_data    (cq_data),
        .tdown_done (tdown_done)
    );

    assign dp_enable    = run_lvl;
    assign dp_pause     = run_lvl && ctl_pause;
    assign peer_en_o    = pen_en;
    assign peer_flush_o = pen_flush;
    assign stat_xy      = xy_q;
    assign stat_z       = z_q;

    // ---------------- read mux ----------------
    logic [31:0] ctl_word, pen_word;

    always_comb begin
        ctl_word            = '0;
        ctl_word[CTL_EN]    = ctl_en;
        ctl_word[CTL_TD]    = ctl_td;
        ctl_word[CTL_PAUSE] = ctl_pause;
        ctl_word[CTL_FTD]   = ctl_ftd;
        ctl_word[CTL_ERR]   = ctl_err;
        pen_word            = '0;
        pen_word[PEN_EN]    = pen_en;
        pen_word[PEN_TD]    = pen_td;
        pen_word[PEN_PAUSE] = pen_pause;
        pen_word[PEN_FLUSH] = pen_flush;
        pen_word[PEN_IDLE]  = (fsm_state == ST_IDLE);
    end

    always_comb begin
        bus_rdata = '0;
        if (is_ctl) begin
            bus_rdata = ctl_word;
        end else if (is_sd) begin
            bus_rdata = sd_rdata;
        end else if (is_peer) begin
            if (pidx == PIW'(PIDX_XY))       bus_rdata = xy_q;
            else if (pidx == PIW'(PIDX_Z))   bus_rdata = z_q;
            else if (pidx == PIW'(PIDX_PBC)) bus_rdata = cnt_val[CNT_PEER];
            else if (pidx == PIW'(PIDX_EN))  bus_rdata = pen_word;
        end else if (is_cnt[CNT_PKT]) begin
            bus_rdata = cnt_val[CNT_PKT];
        end else if (is_cnt[CNT_BYTE]) begin
            bus_rdata = cnt_val[CNT_BYTE];
        end else if (is_cnt[CNT_SBYTE]) begin
            bus_rdata = cnt_val[CNT_SBYTE];
        end
    end
endmodule

// File: rtl/dma_txch_rt_chk.sv
module dma_txch_rt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cq_valid,
    input logic        cq_ready,
    input logic [31:0] cq_data,
    input logic        dp_enable,
    input logic        dp_pause,
    input logic        desc_valid,
    input logic        desc_ready,
    input logic        cnt_ok
);
    p_cq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cq_valid && !cq_ready |=> cq_valid && $stable(cq_data));

    p_withhold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cq_valid) && !cq_data[0] |-> $past(cnt_ok));

    p_desc_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && desc_ready |=> !cq_valid);

    p_selfclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cq_valid && cq_ready && cq_data[0] |=> !dp_enable);

    p_pause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dp_pause |-> dp_enable);

    p_marker_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cq_valid && !dp_enable |-> cq_data[0]);
endmodule

bind dma_txch_rt dma_txch_rt_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cq_valid   (cq_valid),
    .cq_ready   (cq_ready),
    .cq_data    (cq_data),
    .dp_enable  (dp_enable),
    .dp_pause   (dp_pause),
    .desc_valid (desc_valid),
    .desc_ready (desc_ready),
    .cnt_ok     (cnt_ok)
);

// File: tb/sim_dma_txch_rt.sv
module sim_dma_txch_rt;
    localparam int AW = 12;
    localparam int INC_W = 16;
    localparam int SD_IW = 5;
    localparam int NV = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic bus_we = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic dp_enable, dp_pause, desc_ready, cq_valid, peer_en_o, peer_flush_o;
    logic dp_busy = 0, dp_error = 0, pkt_inc = 0, sd_we = 0, desc_valid = 0, cq_ready = 0;
    logic [INC_W-1:0] byte_inc = '0, peer_byte_inc = '0;
    logic [SD_IW-1:0] sd_idx = '0;
    logic [31:0] sd_data = '0, desc_addr = '0, cq_data, stat_xy, stat_z;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dma_txch_rt u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dp_enable(dp_enable),
        .dp_pause(dp_pause), .dp_busy(dp_busy), .dp_error(dp_error),
        .pkt_inc(pkt_inc), .byte_inc(byte_inc), .peer_byte_inc(peer_byte_inc),
        .sd_we(sd_we), .sd_idx(sd_idx), .sd_data(sd_data),
        .desc_valid(desc_valid), .desc_addr(desc_addr), .desc_ready(desc_ready),
        .cq_valid(cq_valid), .cq_data(cq_data), .cq_ready(cq_ready),
        .peer_en_o(peer_en_o), .peer_flush_o(peer_flush_o),
        .stat_xy(stat_xy), .stat_z(stat_z)
    );

    // {we, addr, wdata, expected read}
    localparam logic [76:0] VEC [NV] = '{
        {1'b1, 12'h200, 32'hFFFF_FFFF, 32'h0},           // R5 XY write
        {1'b0, 12'h200, 32'h0, 32'hC700_0FFF},           // R5 XY keeps fields
        {1'b1, 12'h204, 32'hFFFF_FFFF, 32'h0},           // R5 Z write
        {1'b0, 12'h204, 32'h0, 32'h0000_FFFF},           // R5 Z masked
        {1'b0, 12'h208, 32'h0, 32'h0},                   // R5 unused peer slot
        {1'b0, 12'h23C, 32'h0, 32'h0},                   // R5 last peer slot
        {1'b1, 12'h300, 32'hDEAD_BEEF, 32'h0},           // R12 unmapped write
        {1'b0, 12'h300, 32'h0, 32'h0},                   // R12 unmapped read
        {1'b1, 12'h080, 32'h1234_5678, 32'h0},           // R6 software write
        {1'b0, 12'h080, 32'h0, 32'hA5A5_0001},           // R6 unchanged
        {1'b0, 12'h0FC, 32'h0, 32'h5A5A_FFFE},           // R6 top word
        {1'b1, 12'h220, 32'hFFFF_FFFF, 32'h0},           // R5 peer enable write
        {1'b0, 12'h220, 32'h0, 32'hF000_0002},           // R5 peer bits plus idle
        {1'b1, 12'h220, 32'h0, 32'h0},                   // R5 peer clear
        {1'b1, 12'h000, 32'h2000_0000, 32'h0},           // R2 pause only
        {1'b0, 12'h000, 32'h0, 32'h2000_0000}            // R2 readback
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_cq(input int n);
        for (int i = 0; i < n; i++) begin
            if (cq_valid) break;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic take_cq;
        cq_ready = 1;
        @(negedge clk);
        cq_ready = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1 reset state
        rd(12'h000, v); check("R1 ctl", v, 32'h0);
        rd(12'h220, v); check("R1 peer idle", v, 32'h2);
        rd(12'h408, v); check("R1 byte cnt", v, 32'h0);
        check("R1 outputs", {28'h0, dp_enable, dp_pause, desc_ready, cq_valid}, 32'h0);

        // datapath fills state words
        @(negedge clk); sd_we = 1; sd_idx = 0; sd_data = 32'hA5A5_0001;
        @(negedge clk); sd_idx = 31; sd_data = 32'h5A5A_FFFE;
        @(negedge clk); sd_we = 0;

        // R5 R6 R12 R2 table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][76]) begin
                wr(VEC[i][75:64], VEC[i][63:32]);
            end else begin
                rd(VEC[i][75:64], v);
                check($sformatf("R5 R6 R12 table %0d", i), v, VEC[i][31:0]);
            end
        end
        check("R2 no pause while idle", {31'h0, dp_pause}, 32'h0);

        // R2 start and pause
        wr(12'h000, 32'h8000_0000);
        cyc(2);
        check("R2 enable", {31'h0, dp_enable}, 32'h1);
        wr(12'h000, 32'hA000_0000);
        check("R2 pause", {31'h0, dp_pause}, 32'h1);
        wr(12'h000, 32'h8000_0000);
        check("R2 unpause", {31'h0, dp_pause}, 32'h0);

        // R3 increments
        @(negedge clk); byte_inc = 100; pkt_inc = 1;
        @(negedge clk); byte_inc = 0; pkt_inc = 0;

        // R7 descriptor held until peer catches up
        @(negedge clk); desc_valid = 1; desc_addr = 32'h0000_1235; #1;
        check("R7 ready in run", {31'h0, desc_ready}, 32'h1);
        @(negedge clk); desc_valid = 0;
        cyc(3); #1;
        check("R7 withheld", {31'h0, cq_valid}, 32'h0);
        @(negedge clk); peer_byte_inc = 100;
        @(negedge clk); peer_byte_inc = 0;
        @(negedge clk); #1;
        check("R7 valid", {31'h0, cq_valid}, 32'h1);
        check("R7 addr bit0 clear", cq_data, 32'h0000_1234);
        @(negedge clk); #1;
        check("R11 held", {cq_data[31:1], cq_valid}, {31'h0000_091A, 1'b1});
        take_cq; #1;
        check("R7 delivered", {31'h0, cq_valid}, 32'h0);

        rd(12'h400, v); check("R3 pkt", v, 32'd1);
        rd(12'h408, v); check("R3 byte", v, 32'd100);
        rd(12'h410, v); check("R3 sbyte", v, 32'd100);
        rd(12'h210, v); check("R3 peer byte", v, 32'd100);

        // R4 write subtracts, same-cycle increment added after
        @(negedge clk); bus_we = 1; bus_addr = 12'h408; bus_wdata = 30; byte_inc = 5;
        @(negedge clk); bus_we = 0; byte_inc = 0;
        rd(12'h408, v); check("R4 sub plus inc", v, 32'd75);
        rd(12'h410, v); check("R4 sbyte untouched", v, 32'd105);
        wr(12'h408, 32'd1000);
        rd(12'h408, v); check("R4 saturate", v, 32'd0);
        wr(12'h400, 32'd1);
        rd(12'h400, v); check("R4 pkt clear", v, 32'd0);

        // R8 teardown handshake
        dp_busy = 1;
        wr(12'h000, 32'hC000_0000);
        cyc(4); #1;
        check("R8 draining", {30'h0, dp_enable, cq_valid}, 32'h2);
        wr(12'h220, 32'h9000_0000);
        check("R8 peer flush", {30'h0, peer_en_o, peer_flush_o}, 32'h3);
        cyc(3); #1;
        check("R8 busy blocks", {31'h0, cq_valid}, 32'h0);
        dp_busy = 0;
        wait_cq(6);
        check("R8 marker", {cq_valid, cq_data[30:0]}, 32'h8000_0001);
        take_cq; #1;
        check("R10 disabled", {31'h0, dp_enable}, 32'h0);
        rd(12'h000, v); check("R10 ctl cleared", v, 32'h0);
        rd(12'h220, v); check("R10 peer cleared", v, 32'h2);
        cyc(3); #1;
        check("R10 stays idle", {31'h0, dp_enable}, 32'h0);
        wr(12'h000, 32'h8000_0000);
        cyc(2);
        check("R10 restart", {31'h0, dp_enable}, 32'h1);

        // R9 forced teardown skips drain
        dp_busy = 1;
        wr(12'h000, 32'h9000_0000);
        wait_cq(6);
        check("R9 forced marker", {cq_valid, cq_data[30:0]}, 32'h8000_0001);
        take_cq; #1;
        check("R9 disabled", {31'h0, dp_enable}, 32'h0);
        dp_busy = 0;

        // R13 error bit
        @(negedge clk); dp_error = 1;
        @(negedge clk); dp_error = 0;
        rd(12'h000, v); check("R13 error set", v, 32'h1);
        wr(12'h000, 32'h0000_0001);
        rd(12'h000, v); check("R13 write one keeps", v, 32'h1);
        wr(12'h000, 32'h0);
        rd(12'h000, v); check("R13 error cleared", v, 32'h0);
        check("R7 no accept idle", {31'h0, desc_ready}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule